// File: doc/BRIEF.md
# Accelerator Signal Edge Time-Stamper

This block places asynchronous accelerator timing signals on the time base of a local master clock. It keeps a 64-bit timestamp counter that runs on the master clock. It watches two asynchronous lines. The first is a Manchester-coded serial clock/data line. The second is a separate spill-sync line. Both lines are brought into the clock domain and searched for edges. Every timestamp is moved back by the fixed synchroniser latency, so it names the clock edge that first sampled the new level.

Every edge of the sync line becomes a record. The serial line is decoded into bytes, and each good byte becomes a record stamped with the time of its start bit. The serial line toggles at roughly ten million edges per second, which is too many to read out. Its edges are therefore thinned to one phase-tracking record per programmable number of edges.

All records leave on a single valid/ready stream. Each record carries a kind, a timestamp and a payload byte. When that stream is stalled and a record cannot be held, the record is dropped and counted.

Top module: `acc_edge_stamper`

## Requirements
- R1: While reset is asserted and immediately after it, the outputs are as follows: `rec_valid_o`=0, `frame_err_o`=0, `drop_cnt_o`=0, and the timestamp counter is 0. The counter then increases by one on every clock edge out of reset.
- R2: Every edge of `sync_i`, rising or falling, produces one record of kind 0. Its payload bit 0 is the new level. Its timestamp is the counter value at the first clock edge that samples the new level.
- R3: A serial frame produces a record of kind 1 that carries the data byte. Its timestamp is that of the start bit's mid-bit transition. The frame is laid out as follows:
  - The idle line is low.
  - Each bit's value is the line level in its second half.
  - A start bit of 1 comes first.
  - 8 data bits follow, LSB first.
  - A stop bit of 0 ends the frame.
- R4: A transition seen fewer than `WIN_LO` samples after the last accepted mid-bit transition is a bit-boundary transition and is ignored. Frames with a 6-sample bit period therefore decode for any data value and raise no error.
- R5: A stop bit of 1 discards the byte and sets `frame_err_o`. The flag stays set until reset.
- R6: Inside a frame, more than `WIN_HI` samples without a mid-bit transition discards the byte and sets `frame_err_o`.
- R7: Serial-line edges (both polarities) are counted. The N-th edge, the 2N-th edge and so on each produce a record of kind 2. N is the value of `decim_i`, and N=0 acts as 1. The payload bit 0 is the new level and the timestamp is corrected as in R2. Kind 3 is never emitted.
- R8: While `rec_valid_o` is high and `rec_ready_i` is low, the record on the outputs does not change.
- R9: Each record kind has one holding slot. A record that arrives while its slot is still occupied and not being drained is dropped. Each drop increments `drop_cnt_o`, which saturates and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Asynchronous Manchester serial line |
| sync_i | input | 1 | Asynchronous spill-sync line |
| decim_i | input | DECIM_W | Phase record interval N |
| rec_ready_i | input | 1 | Consumer accepts record |
| rec_valid_o | output | 1 | Record present |
| rec_type_o | output | 2 | Record kind: 0 sync edge, 1 byte, 2 phase |
| rec_ts_o | output | 64 | Corrected timestamp |
| rec_data_o | output | 8 | Payload |
| frame_err_o | output | 1 | Sticky framing error |
| drop_cnt_o | output | DROP_W | Saturating count of dropped records |

## Verification
The assertions assume the following about the inputs:
- Both lines hold each level for at least a few clocks, so no pulse is shorter than the synchroniser can resolve.
- Serial edges fall no closer than three samples apart, which keeps the decoder inside its window.
- `decim_i` stays steady while serial edges are arriving.

The stimulus changes both lines only on falling clock edges. It uses half-bit periods of exactly three clocks. It changes the interval only while the serial line is idle, and it never toggles the two lines in the same stretch. Stalls are applied only while the sync line is active, so the expected drops can be computed exactly.

// File: rtl/acc_ts_pkg.sv
`timescale 1ns/1ps
package acc_ts_pkg;
  localparam int TS_W  = 64;
  localparam int DAT_W = 8;
  localparam int N_SRC = 3;

  typedef enum logic [1:0] {
    REC_SYNC  = 2'd0,
    REC_BYTE  = 2'd1,
    REC_PHASE = 2'd2,
    REC_RSVD  = 2'd3
  } rec_kind_e;

  typedef struct packed {
    rec_kind_e          kind;
    logic [TS_W-1:0]    ts;
    logic [DAT_W-1:0]   data;
  } rec_t;
endpackage

// File: rtl/acc_sync2.sv
`timescale 1ns/1ps
module acc_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/acc_mdec.sv
`timescale 1ns/1ps
module acc_mdec
  import acc_ts_pkg::*;
#(
  parameter int WIN_LO = 4,
  parameter int WIN_HI = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             edge_i,
  input  logic [TS_W-1:0]  ts_edge_i,
  output logic             byte_v_o,
  output logic [DAT_W-1:0] byte_o,
  output logic [TS_W-1:0]  byte_ts_o,
  output logic             err_o
);
  localparam int CW = $clog2(WIN_HI + 2);
  localparam logic [CW-1:0] LO_C = CW'(WIN_LO);
  localparam logic [CW-1:0] HI_C = CW'(WIN_HI);

  typedef enum logic {M_IDLE, M_RX} mst_e;

  mst_e             st_q;
  logic [CW-1:0]    cnt_q;
  logic [3:0]       idx_q;
  logic [DAT_W-1:0] sh_q;
  logic [TS_W-1:0]  ts_q;
  logic             bv_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= M_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      ts_q  <= '0;
      bv_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      bv_q  <= 1'b0;
      err_q <= 1'b0;
      unique case (st_q)
        M_IDLE: begin
          // only a rising transition can be a start bit mid-point
          if (edge_i && lvl_i) begin
            st_q  <= M_RX;
            cnt_q <= CW'(1);
            idx_q <= '0;
            ts_q  <= ts_edge_i;
          end
        end
        M_RX: begin
          if (edge_i && cnt_q >= LO_C) begin
            cnt_q <= CW'(1);
            if (idx_q == 4'd8) begin
              st_q <= M_IDLE;
              if (!lvl_i) bv_q  <= 1'b1;
              else        err_q <= 1'b1;
            end else begin
              sh_q  <= {lvl_i, sh_q[DAT_W-1:1]};
              idx_q <= idx_q + 4'd1;
            end
          end else if (cnt_q > HI_C) begin
            st_q  <= M_IDLE;
            err_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign byte_v_o  = bv_q;
  assign byte_o    = sh_q;
  assign byte_ts_o = ts_q;
  assign err_o     = err_q;
endmodule

// File: rtl/acc_rec_arb.sv
`timescale 1ns/1ps
module acc_rec_arb
  import acc_ts_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  in_v_i,
  input  rec_t [N_SRC-1:0]  in_rec_i,
  input  logic              ready_i,
  output logic              out_v_o,
  output rec_t              out_rec_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int SEL_W = $clog2(N_SRC);

  logic [N_SRC-1:0] pend_v, gnt, drop_hit;
  rec_t [N_SRC-1:0] pend_r;
  logic [SEL_W-1:0] sel;
  logic             out_v_q, out_free;
  rec_t             out_q;
  logic [DROP_W-1:0] drop_q;
  logic [DROP_W:0]   drop_sum;

  assign out_free = !out_v_q || ready_i;

  // lowest index wins
  always_comb begin
    gnt = '0;
    sel = '0;
    if (out_free) begin
      for (int i = N_SRC - 1; i >= 0; i--) begin
        if (pend_v[i]) begin
          gnt    = '0;
          gnt[i] = 1'b1;
          sel    = SEL_W'(i);
        end
      end
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    logic v_q;
    rec_t r_q;
    assign drop_hit[g] = in_v_i[g] && v_q && !gnt[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        r_q <= '0;
      end else if (in_v_i[g] && !drop_hit[g]) begin
        v_q <= 1'b1;
        r_q <= in_rec_i[g];
      end else if (gnt[g]) begin
        v_q <= 1'b0;
      end
    end
    assign pend_v[g] = v_q;
    assign pend_r[g] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else if (out_free) begin
      out_v_q <= |gnt;
      if (|gnt) out_q <= pend_r[sel];
    end
  end

  always_comb drop_sum = {1'b0, drop_q} + (DROP_W+1)'($countones(drop_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               drop_q <= '0;
    else if (drop_sum[DROP_W]) drop_q <= '1;
    else                       drop_q <= drop_sum[DROP_W-1:0];
  end

  assign out_v_o    = out_v_q;
  assign out_rec_o  = out_q;
  assign drop_cnt_o = drop_q;
endmodule

// File: rtl/acc_edge_stamper.sv
`timescale 1ns/1ps
module acc_edge_stamper
  import acc_ts_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DECIM_W     = 16,
  parameter int DROP_W      = 16,
  parameter int WIN_LO      = 4,
  parameter int WIN_HI      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_i,
  input  logic               sync_i,
  input  logic [DECIM_W-1:0] decim_i,
  input  logic               rec_ready_i,
  output logic               rec_valid_o,
  output logic [1:0]         rec_type_o,
  output logic [TS_W-1:0]    rec_ts_o,
  output logic [DAT_W-1:0]   rec_data_o,
  output logic               frame_err_o,
  output logic [DROP_W-1:0]  drop_cnt_o
);
  localparam int LAT       = SYNC_STAGES;
  localparam int N_IN      = 2;
  localparam int IN_SER    = 0;
  localparam int IN_SYNC   = 1;
  localparam int SRC_SYNC  = 0;
  localparam int SRC_BYTE  = 1;
  localparam int SRC_PHASE = 2;

  logic [TS_W-1:0] ts_q, ts_edge;
  logic [N_IN-1:0] raw, lvl, lvl_d_q, edg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + TS_W'(1);
  end

  assign raw = {sync_i, ser_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    acc_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (lvl[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= '0;
    else         lvl_d_q <= lvl;
  end

  assign edg     = lvl ^ lvl_d_q;
  assign ts_edge = ts_q - TS_W'(LAT);

  // phase decimation
  logic [DECIM_W-1:0] decim_q, ecnt_q;
  logic [DECIM_W:0]   ecnt_nx;
  logic               phase_last, phase_hit;

  assign ecnt_nx    = {1'b0, ecnt_q} + (DECIM_W+1)'(1);
  assign phase_last = (decim_q == '0) || (ecnt_nx >= {1'b0, decim_q});
  assign phase_hit  = edg[IN_SER] && phase_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decim_q <= '0;
      ecnt_q  <= '0;
    end else begin
      decim_q <= decim_i;
      if (edg[IN_SER]) ecnt_q <= phase_last ? '0 : ecnt_nx[DECIM_W-1:0];
    end
  end

  // Manchester decode
  logic             byte_v, dec_err, err_q;
  logic [DAT_W-1:0] byte_d;
  logic [TS_W-1:0]  byte_ts;

  acc_mdec #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_mdec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl[IN_SER]),
    .edge_i   (edg[IN_SER]),
    .ts_edge_i(ts_edge),
    .byte_v_o (byte_v),
    .byte_o   (byte_d),
    .byte_ts_o(byte_ts),
    .err_o    (dec_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | dec_err;
  end

  // record sources
  logic [N_SRC-1:0] in_v;
  rec_t [N_SRC-1:0] in_rec;
  logic             out_v;
  rec_t             out_rec;

  always_comb begin
    in_v                  = '0;
    in_v[SRC_SYNC]        = edg[IN_SYNC];
    in_v[SRC_BYTE]        = byte_v;
    in_v[SRC_PHASE]       = phase_hit;
    in_rec                = '0;
    in_rec[SRC_SYNC].kind = REC_SYNC;
    in_rec[SRC_SYNC].ts   = ts_edge;
    in_rec[SRC_SYNC].data = {{(DAT_W-1){1'b0}}, lvl[IN_SYNC]};
    in_rec[SRC_BYTE].kind = REC_BYTE;
    in_rec[SRC_BYTE].ts   = byte_ts;
    in_rec[SRC_BYTE].data = byte_d;
    in_rec[SRC_PHASE].kind = REC_PHASE;
    in_rec[SRC_PHASE].ts   = ts_edge;
    in_rec[SRC_PHASE].data = {{(DAT_W-1){1'b0}}, lvl[IN_SER]};
  end

  acc_rec_arb #(.DROP_W(DROP_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_v_i    (in_v),
    .in_rec_i  (in_rec),
    .ready_i   (rec_ready_i),
    .out_v_o   (out_v),
    .out_rec_o (out_rec),
    .drop_cnt_o(drop_cnt_o)
  );

  assign rec_valid_o = out_v;
  assign rec_type_o  = out_rec.kind;
  assign rec_ts_o    = out_rec.ts;
  assign rec_data_o  = out_rec.data;
  assign frame_err_o = err_q;
endmodule

// File: rtl/acc_edge_stamper_chk.sv
`timescale 1ns/1ps
module acc_edge_stamper_chk
  import acc_ts_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rec_ready_i,
  input logic              rec_valid_o,
  input logic [1:0]        rec_type_o,
  input logic [TS_W-1:0]   rec_ts_o,
  input logic [DAT_W-1:0]  rec_data_o,
  input logic              frame_err_o,
  input logic [DROP_W-1:0] drop_cnt_o,
  input logic [TS_W-1:0]   ts_now_i
);
  p_ts_in_past_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_ts_o < ts_now_i));

  p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);

  p_kind_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_type_o != 2'd3));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_type_o)
                                       && $stable(rec_ts_o) && $stable(rec_data_o)));

  p_drop_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drop_cnt_o >= $past(drop_cnt_o)));

  p_clock_runs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ts_now_i != $past(ts_now_i)));
endmodule

bind acc_edge_stamper acc_edge_stamper_chk #(.DROP_W(DROP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rec_ready_i(rec_ready_i),
  .rec_valid_o(rec_valid_o),
  .rec_type_o (rec_type_o),
  .rec_ts_o   (rec_ts_o),
  .rec_data_o (rec_data_o),
  .frame_err_o(frame_err_o),
  .drop_cnt_o (drop_cnt_o),
  .ts_now_i   (ts_q)
);

// File: tb/sim_acc_edge_stamper.sv
`timescale 1ns/1ps
module sim_acc_edge_stamper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser = 1'b0;
  logic        sync = 1'b0;
  logic        ready = 1'b1;
  logic [15:0] dec = 16'd1;

  logic        rec_valid;
  logic [1:0]  rec_type;
  logic [63:0] rec_ts;
  logic [7:0]  rec_data;
  logic        frame_err;
  logic [15:0] drop_cnt;

  acc_edge_stamper u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ser_i      (ser),
    .sync_i     (sync),
    .decim_i    (dec),
    .rec_ready_i(ready),
    .rec_valid_o(rec_valid),
    .rec_type_o (rec_type),
    .rec_ts_o   (rec_ts),
    .rec_data_o (rec_data),
    .frame_err_o(frame_err),
    .drop_cnt_o (drop_cnt)
  );

  always #2.5 clk = ~clk;

  int          total = 0;
  int          bad = 0;
  int          ecnt = 0;
  logic [63:0] bcnt = '0;
  logic [71:0] q_sync[$];
  logic [71:0] q_byte[$];
  logic [71:0] q_phase[$];

  always @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= bcnt + 64'd1;
  end

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // record comparison on every accepted transfer
  always begin
    @(negedge clk);
    #1;
    if (rst_n && rec_valid && ready) begin
      logic [71:0] got, e;
      got = {rec_ts, rec_data};
      case (rec_type)
        2'd0: if (q_sync.size() == 0) chk(0, "R2 unexpected sync record", got, 0);
              else begin e = q_sync.pop_front(); chk(got == e, "R2 sync record", got, e); end
        2'd1: if (q_byte.size() == 0) chk(0, "R3 unexpected byte record", got, 0);
              else begin e = q_byte.pop_front(); chk(got == e, "R3 byte record", got, e); end
        2'd2: if (q_phase.size() == 0) chk(0, "R7 unexpected phase record", got, 0);
              else begin e = q_phase.pop_front(); chk(got == e, "R7 phase record", got, e); end
        default: chk(0, "R7 illegal kind", {70'd0, rec_type}, 0);
      endcase
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_set(input logic v);
    int eff;
    if (ser != v) begin
      ser = v;
      eff = (dec == 0) ? 1 : int'(dec);
      if (ecnt + 1 >= eff) begin
        q_phase.push_back({bcnt, 7'd0, v});
        ecnt = 0;
      end else begin
        ecnt++;
      end
    end
  endtask

  task automatic send_bit(input logic v);
    ser_set(~v); hold(3);
    ser_set(v);  hold(3);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    logic [63:0] st;
    ser_set(1'b0); hold(3);
    ser_set(1'b1); st = bcnt; hold(3);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(stop);
    if (!stop) q_byte.push_back({st, b});
  endtask

  task automatic sync_set(input logic v, input bit expect_rec);
    sync = v;
    if (expect_rec) q_sync.push_back({bcnt, 7'd0, v});
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    ecnt  = 0;
    hold(3);
    chk(rec_valid == 1'b0, "R1 valid low in reset", {71'd0, rec_valid}, 0);
    chk(frame_err == 1'b0, "R1 error clear in reset", {71'd0, frame_err}, 0);
    chk(drop_cnt == 16'd0, "R1 drop count zero", {56'd0, drop_cnt}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [71:0] snap;
    do_reset();
    hold(5);
    // R2: both polarities
    sync_set(1'b1, 1); hold(8);
    sync_set(1'b0, 1); hold(8);
    sync_set(1'b1, 1); hold(11);
    sync_set(1'b0, 1); hold(8);

    // R3 R4 R7: every edge sampled
    dec = 16'd1; hold(4);
    send_frame(8'hA5, 1'b0); hold(12);
    send_frame(8'h00, 1'b0);
    send_frame(8'hFF, 1'b0); hold(20);

    dec = 16'd3; hold(4);
    send_frame(8'h3C, 1'b0);
    send_frame(8'h81, 1'b0); hold(20);
    chk(frame_err == 1'b0, "R4 no error on clean frames", {71'd0, frame_err}, 0);

    // R5: bad stop bit
    send_frame(8'h5A, 1'b1); hold(10);
    chk(frame_err == 1'b1, "R5 stop bit error", {71'd0, frame_err}, 1);
    ser_set(1'b0); hold(20);
    chk(frame_err == 1'b1, "R5 error sticky", {71'd0, frame_err}, 1);

    // R6: truncated frame
    do_reset();
    hold(5);
    ser_set(1'b1); hold(3);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    hold(20);
    chk(frame_err == 1'b1, "R6 timeout error", {71'd0, frame_err}, 1);
    ser_set(1'b0); hold(10);

    // R7: interval 0 behaves as 1
    dec = 16'd0;
    do_reset();
    hold(5);
    send_frame(8'hC3, 1'b0); hold(20);

    // R8 R9: stall
    @(negedge clk); ready = 1'b0;
    sync_set(1'b1, 1); hold(8);
    sync_set(1'b0, 1); hold(8);
    sync_set(1'b1, 0); hold(8);
    sync_set(1'b0, 0); hold(5);
    chk(rec_valid == 1'b1, "R8 valid while stalled", {71'd0, rec_valid}, 1);
    snap = {rec_ts, rec_data};
    hold(6);
    chk({rec_ts, rec_data} == snap, "R8 record stable", {rec_ts, rec_data}, snap);
    chk(drop_cnt == 16'd2, "R9 drop count", {56'd0, drop_cnt}, 2);
    ready = 1'b1;
    hold(20);

    chk(q_sync.size() == 0, "R2 all sync records seen", q_sync.size(), 0);
    chk(q_byte.size() == 0, "R3 all bytes seen", q_byte.size(), 0);
    chk(q_phase.size() == 0, "R7 all phase records seen", q_phase.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule